// File: doc/BRIEF.md
# Frame-Coherent Conversion Result Store

This block keeps the most recent results of two converter paths for a serial-read front end. Path one delivers one result word per finished conversion. Path two delivers a packed set of step results each time a multi-step sequence finishes. Each path also has a small rolling completion counter. A reader uses it to tell whether the data it read is new and whether any completions were missed.

A single frame-active input marks a read in progress. While it is high, the visible result words and the counters do not move. Completions that arrive then are held in a per-path holding buffer and applied once the frame closes. Because of this, the counter a reader sees always matches the data returned in the same frame. Disabling a path, or asking for a low-power state, clears that path's counter and drops any held update.

Top module: `rescoh_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, both counters, both visible result buses and both pending flags become 0 at that edge.
- R2: With the frame inactive, the path enabled, low power off and nothing pending, a completion strobe loads its input into the visible result and adds 1 to the path counter at the same edge. The new values show one cycle after the strobe is sampled.
- R3: Each counter is `CNT_W` bits wide (2 by default) and wraps from its largest value (3) back to 0 on the next increment.
- R4: When a path's enable is low or `low_pwr` is high at an edge, that path's counter becomes 0 and its pending flag and held update are discarded. Its completion strobe is ignored and its visible result data is kept as it was.
- R5: While `rd_frame` is high, neither path's visible data nor its counter changes. A completion arriving then is stored in that path's holding buffer, and the path's pending flag (`upd_pend[0]` for path one, `upd_pend[1]` for path two) becomes 1.
- R6: At the first edge where `rd_frame` is sampled low with an update pending, the held data is copied into the visible result. The counter advances by the number of completions held, modulo 2^`CNT_W`, and the pending flag clears unless R8 applies.
- R7: If several completions land during one frame, only the newest data is kept for the commit, while the counter still accounts for all of them.
- R8: A completion that arrives in the same cycle as a commit is not lost. It is held, stays pending, and is committed at the next edge where `rd_frame` is low, adding 1 to the counter.
- R9: Path two's visible bus holds `N_STEP` results of `RES_W` bits, with step k in bits [k*RES_W +: RES_W]. All steps of one sequence are updated at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_frame | input | 1 | High while a read frame is in progress |
| en_p1 | input | 1 | Path one enable |
| en_p2 | input | 1 | Path two enable |
| low_pwr | input | 1 | High when the device is in standby or power-down |
| p1_done | input | 1 | Path one conversion-complete strobe |
| p1_din | input | RES_W | Path one new result |
| p2_done | input | 1 | Path two sequence-complete strobe |
| p2_din | input | N_STEP*RES_W | Path two new step results, packed |
| p1_data | output | RES_W | Path one visible result |
| p1_cnt | output | CNT_W | Path one completion counter |
| p2_data | output | N_STEP*RES_W | Path two visible step results |
| p2_cnt | output | CNT_W | Path two completion counter |
| upd_pend | output | 2 | Held update waiting for commit (bit 0 path one, bit 1 path two) |

## Verification
The bench goes after the frame boundary. A design that updates during the frame, or that commits while the frame is still high, returns data and counters from different sequences. Several completions in one frame, including exactly four, test the modulo advance. A design that counts only one completion, or keeps the oldest data, reports the wrong counter or stale steps. A strobe in the commit cycle catches a design that drops it. Clearing a path while an update is held catches a design that commits discarded data after the clear.

// File: rtl/rescoh_pkg.sv
package rescoh_pkg;

   // What a lane does at the coming clock edge.
   typedef enum logic [2:0] {
      ACT_IDLE       = 3'd0,
      ACT_CLEAR      = 3'd1,
      ACT_HOLDIN     = 3'd2,
      ACT_DIRECT     = 3'd3,
      ACT_COMMIT     = 3'd4,
      ACT_COMMIT_CAP = 3'd5
   } lane_act_e;

endpackage

// File: rtl/rescoh_ctr.sv
module rescoh_ctr #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add_en,
   input  logic [CNT_W-1:0] add_val,
   output logic [CNT_W-1:0] cnt
);

   initial assert (CNT_W >= 1) else $error("rescoh_ctr: CNT_W must be at least 1");

   // The sum is truncated to CNT_W bits, so the counter wraps modulo 2^CNT_W.
   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt <= '0;
      end else if (add_en) begin
         cnt <= cnt + add_val;
      end
   end

endmodule

// File: rtl/rescoh_lane.sv
module rescoh_lane
   import rescoh_pkg::*;
#(
   parameter int SLICE_W = 24,
   parameter int N_SLICE = 1,
   parameter int CNT_W   = 2,
   localparam int DW     = SLICE_W * N_SLICE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             frame,
   input  logic             done,
   input  logic [DW-1:0]    din,
   output logic [DW-1:0]    vis_data,
   output logic [CNT_W-1:0] vis_cnt,
   output logic             pend
);

   initial assert (SLICE_W >= 1) else $error("rescoh_lane: SLICE_W must be at least 1");
   initial assert (N_SLICE >= 1) else $error("rescoh_lane: N_SLICE must be at least 1");

   lane_act_e        act;
   logic [DW-1:0]    hold_data;
   logic [CNT_W-1:0] hold_num;
   logic             pend_q;
   logic             cnt_add;
   logic [CNT_W-1:0] cnt_val;
   logic             load_new;
   logic             load_held;

   // Decide what happens at this edge. Clear wins, then the frame freeze,
   // then the commit of a held update, then a direct update.
   always_comb begin
      if (clr) begin
         act = ACT_CLEAR;
      end else if (frame) begin
         act = done ? ACT_HOLDIN : ACT_IDLE;
      end else if (pend_q) begin
         act = done ? ACT_COMMIT_CAP : ACT_COMMIT;
      end else begin
         act = done ? ACT_DIRECT : ACT_IDLE;
      end
   end

   assign load_new  = (act == ACT_DIRECT);
   assign load_held = (act == ACT_COMMIT) || (act == ACT_COMMIT_CAP);

   always_comb begin
      cnt_add = 1'b0;
      cnt_val = '0;
      if (load_new) begin
         cnt_add = 1'b1;
         cnt_val = CNT_W'(1);
      end else if (load_held) begin
         cnt_add = 1'b1;
         cnt_val = hold_num;
      end
   end

   // Holding buffer: keeps only the newest data and counts the completions.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_data <= '0;
         hold_num  <= '0;
         pend_q    <= 1'b0;
      end else begin
         unique case (act)
            ACT_CLEAR, ACT_COMMIT: begin
               hold_num <= '0;
               pend_q   <= 1'b0;
            end
            ACT_HOLDIN: begin
               hold_data <= din;
               hold_num  <= pend_q ? hold_num + CNT_W'(1) : CNT_W'(1);
               pend_q    <= 1'b1;
            end
            ACT_COMMIT_CAP: begin
               hold_data <= din;
               hold_num  <= CNT_W'(1);
               pend_q    <= 1'b1;
            end
            default: begin
               pend_q <= pend_q;
            end
         endcase
      end
   end

   // Visible result storage, one register per slice.
   for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vis_data[s*SLICE_W +: SLICE_W] <= '0;
         end else if (load_new) begin
            vis_data[s*SLICE_W +: SLICE_W] <= din[s*SLICE_W +: SLICE_W];
         end else if (load_held) begin
            vis_data[s*SLICE_W +: SLICE_W] <= hold_data[s*SLICE_W +: SLICE_W];
         end
      end
   end

   rescoh_ctr #(.CNT_W(CNT_W)) i_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .add_en  (cnt_add),
      .add_val (cnt_val),
      .cnt     (vis_cnt)
   );

   assign pend = pend_q;

endmodule

// File: rtl/rescoh_top.sv
module rescoh_top #(
   parameter int RES_W  = 24,
   parameter int N_STEP = 4,
   parameter int CNT_W  = 2,
   localparam int P2_W  = RES_W * N_STEP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_frame,
   input  logic              en_p1,
   input  logic              en_p2,
   input  logic              low_pwr,
   input  logic              p1_done,
   input  logic [RES_W-1:0]  p1_din,
   input  logic              p2_done,
   input  logic [P2_W-1:0]   p2_din,
   output logic [RES_W-1:0]  p1_data,
   output logic [CNT_W-1:0]  p1_cnt,
   output logic [P2_W-1:0]   p2_data,
   output logic [CNT_W-1:0]  p2_cnt,
   output logic [1:0]        upd_pend
);

   initial assert (RES_W >= 1)  else $error("rescoh_top: RES_W must be at least 1");
   initial assert (N_STEP >= 1) else $error("rescoh_top: N_STEP must be at least 1");
   initial assert (CNT_W >= 1)  else $error("rescoh_top: CNT_W must be at least 1");

   logic clr_p1;
   logic clr_p2;

   assign clr_p1 = !en_p1 || low_pwr;
   assign clr_p2 = !en_p2 || low_pwr;

   rescoh_lane #(.SLICE_W(RES_W), .N_SLICE(1), .CNT_W(CNT_W)) i_lane_p1 (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_p1),
      .frame    (rd_frame),
      .done     (p1_done),
      .din      (p1_din),
      .vis_data (p1_data),
      .vis_cnt  (p1_cnt),
      .pend     (upd_pend[0])
   );

   rescoh_lane #(.SLICE_W(RES_W), .N_SLICE(N_STEP), .CNT_W(CNT_W)) i_lane_p2 (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_p2),
      .frame    (rd_frame),
      .done     (p2_done),
      .din      (p2_din),
      .vis_data (p2_data),
      .vis_cnt  (p2_cnt),
      .pend     (upd_pend[1])
   );

endmodule

// File: rtl/rescoh_chk.sv
module rescoh_chk #(
   parameter int RES_W  = 24,
   parameter int N_STEP = 4,
   parameter int CNT_W  = 2,
   localparam int P2_W  = RES_W * N_STEP
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_frame,
   input logic              en_p1,
   input logic              en_p2,
   input logic              low_pwr,
   input logic              p1_done,
   input logic [RES_W-1:0]  p1_din,
   input logic              p2_done,
   input logic [P2_W-1:0]   p2_din,
   input logic [RES_W-1:0]  p1_data,
   input logic [CNT_W-1:0]  p1_cnt,
   input logic [P2_W-1:0]   p2_data,
   input logic [CNT_W-1:0]  p2_cnt,
   input logic [1:0]        upd_pend
);

   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (p1_cnt == '0 && p2_cnt == '0 && upd_pend == 2'b00));

   assert_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_p1 && !low_pwr && !rd_frame && !upd_pend[0] && p1_done)
      |=> (p1_cnt == CNT_W'($past(p1_cnt) + 1'b1) && p1_data == $past(p1_din)));

   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_p2 || low_pwr) |=> (p2_cnt == '0 && !upd_pend[1]));

   assert_data_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_frame |=> ($stable(p1_data) && $stable(p2_data)));

   assert_cnt_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_frame && en_p1 && en_p2 && !low_pwr) |=> ($stable(p1_cnt) && $stable(p2_cnt)));

   assert_hold_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_frame && en_p2 && !low_pwr && p2_done) |=> upd_pend[1]);

   assert_no_spurious_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_frame && !upd_pend[1] && !p2_done) |=> !upd_pend[1]);

   assert_commit_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_frame && upd_pend[1] && !p2_done) |=> !upd_pend[1]);

   assert_commit_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_frame && en_p2 && !low_pwr && upd_pend[1] && p2_done) |=> upd_pend[1]);

endmodule

bind rescoh_top rescoh_chk #(.RES_W(RES_W), .N_STEP(N_STEP), .CNT_W(CNT_W)) i_rescoh_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_frame (rd_frame),
   .en_p1    (en_p1),
   .en_p2    (en_p2),
   .low_pwr  (low_pwr),
   .p1_done  (p1_done),
   .p1_din   (p1_din),
   .p2_done  (p2_done),
   .p2_din   (p2_din),
   .p1_data  (p1_data),
   .p1_cnt   (p1_cnt),
   .p2_data  (p2_data),
   .p2_cnt   (p2_cnt),
   .upd_pend (upd_pend)
);

// File: tb/test_rescoh_top.sv
module test_rescoh_top;

   localparam int RES_W  = 24;
   localparam int N_STEP = 4;
   localparam int CNT_W  = 2;
   localparam int P2_W   = RES_W * N_STEP;

   typedef struct {
      string             tag;
      logic [RES_W-1:0]  d1;
      logic [CNT_W-1:0]  c1;
      logic [P2_W-1:0]   d2;
      logic [CNT_W-1:0]  c2;
      logic [1:0]        pd;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rd_frame = 1'b0;
   logic              en_p1 = 1'b0;
   logic              en_p2 = 1'b0;
   logic              low_pwr = 1'b0;
   logic              p1_done = 1'b0;
   logic [RES_W-1:0]  p1_din = '0;
   logic              p2_done = 1'b0;
   logic [P2_W-1:0]   p2_din = '0;
   logic [RES_W-1:0]  p1_data;
   logic [CNT_W-1:0]  p1_cnt;
   logic [P2_W-1:0]   p2_data;
   logic [CNT_W-1:0]  p2_cnt;
   logic [1:0]        upd_pend;

   int   n_chk = 0;
   int   n_err = 0;
   bit   done_all = 1'b0;
   exp_t sb[$];

   // Requirement-level model of each path.
   logic [RES_W-1:0] m_v1, m_h1;
   logic [CNT_W-1:0] m_c1, m_n1;
   logic             m_p1;
   logic [P2_W-1:0]  m_v2, m_h2;
   logic [CNT_W-1:0] m_c2, m_n2;
   logic             m_p2;

   always #2 clk = ~clk;

   rescoh_top #(.RES_W(RES_W), .N_STEP(N_STEP), .CNT_W(CNT_W)) i_rescoh_top (
      .clk(clk), .rst_n(rst_n), .rd_frame(rd_frame), .en_p1(en_p1), .en_p2(en_p2),
      .low_pwr(low_pwr), .p1_done(p1_done), .p1_din(p1_din), .p2_done(p2_done),
      .p2_din(p2_din), .p1_data(p1_data), .p1_cnt(p1_cnt), .p2_data(p2_data),
      .p2_cnt(p2_cnt), .upd_pend(upd_pend)
   );

   function automatic logic [P2_W-1:0] steps(input logic [7:0] seed);
      logic [P2_W-1:0] v;
      for (int k = 0; k < N_STEP; k++) v[k*RES_W +: RES_W] = {seed, 8'(k), 8'hA5 ^ seed};
      return v;
   endfunction

   // Driver: applies one cycle of stimulus and pushes the expected state after the edge.
   task automatic drive(input logic rs, input logic fr, input logic e1, input logic e2,
                        input logic lp, input logic n1, input logic [RES_W-1:0] v1,
                        input logic n2, input logic [P2_W-1:0] v2, input string tag);
      exp_t e;
      @(negedge clk);
      rst_n = rs; rd_frame = fr; en_p1 = e1; en_p2 = e2; low_pwr = lp;
      p1_done = n1; p1_din = v1; p2_done = n2; p2_din = v2;
      if (!rs) begin
         m_v1 = '0; m_h1 = '0; m_c1 = '0; m_n1 = '0; m_p1 = 1'b0;
         m_v2 = '0; m_h2 = '0; m_c2 = '0; m_n2 = '0; m_p2 = 1'b0;
      end else begin
         if (!e1 || lp) begin m_c1 = '0; m_p1 = 1'b0; m_n1 = '0; end
         else if (fr) begin
            if (n1) begin m_h1 = v1; m_n1 = m_p1 ? m_n1 + 1'b1 : 2'd1; m_p1 = 1'b1; end
         end else if (m_p1) begin
            m_v1 = m_h1; m_c1 = m_c1 + m_n1;
            if (n1) begin m_h1 = v1; m_n1 = 2'd1; end else begin m_p1 = 1'b0; m_n1 = '0; end
         end else if (n1) begin m_v1 = v1; m_c1 = m_c1 + 1'b1; end
         if (!e2 || lp) begin m_c2 = '0; m_p2 = 1'b0; m_n2 = '0; end
         else if (fr) begin
            if (n2) begin m_h2 = v2; m_n2 = m_p2 ? m_n2 + 1'b1 : 2'd1; m_p2 = 1'b1; end
         end else if (m_p2) begin
            m_v2 = m_h2; m_c2 = m_c2 + m_n2;
            if (n2) begin m_h2 = v2; m_n2 = 2'd1; end else begin m_p2 = 1'b0; m_n2 = '0; end
         end else if (n2) begin m_v2 = v2; m_c2 = m_c2 + 1'b1; end
      end
      e.tag = tag; e.d1 = m_v1; e.c1 = m_c1; e.d2 = m_v2; e.c2 = m_c2; e.pd = {m_p2, m_p1};
      sb.push_back(e);
   endtask

   // Monitor: compares after each edge, away from the edge itself.
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            e = sb.pop_front();
            n_chk++;
            if (p1_data !== e.d1 || p1_cnt !== e.c1 || p2_data !== e.d2 ||
                p2_cnt !== e.c2 || upd_pend !== e.pd) begin
               n_err++;
               $display("FAIL %s: act d1=%h c1=%0d d2=%h c2=%0d pend=%b exp d1=%h c1=%0d d2=%h c2=%0d pend=%b",
                        e.tag, p1_data, p1_cnt, p2_data, p2_cnt, upd_pend,
                        e.d1, e.c1, e.d2, e.c2, e.pd);
            end
         end
      end
   end

   initial begin
      #(4 * 100000);
      if (!done_all) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: act=running exp=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      for (int i = 0; i < 3; i++) drive(0, 0, 1, 1, 0, 1, 24'h111111, 1, steps(8'h11), "R1 reset");
      // R2: direct updates on both paths
      drive(1, 0, 1, 1, 0, 1, 24'hABC001, 1, steps(8'h21), "R2 direct");
      drive(1, 0, 1, 1, 0, 0, 24'h0, 0, '0, "R2 idle");
      // R3: wrap of path one counter (1 -> 2 -> 3 -> 0)
      drive(1, 0, 1, 1, 0, 1, 24'hABC002, 0, '0, "R3 count");
      drive(1, 0, 1, 1, 0, 1, 24'hABC003, 0, '0, "R3 count");
      drive(1, 0, 1, 1, 0, 1, 24'hABC004, 0, '0, "R3 wrap");
      // R5 / R9: completion during a frame is held, visible frozen
      drive(1, 1, 1, 1, 0, 1, 24'hDEF001, 1, steps(8'h31), "R5 held");
      drive(1, 1, 1, 1, 0, 0, 24'h0, 0, '0, "R5 frozen");
      // R6 / R9: commit at frame end
      drive(1, 0, 1, 1, 0, 0, 24'h0, 0, '0, "R6 commit R9 steps");
      drive(1, 0, 1, 1, 0, 0, 24'h0, 0, '0, "R6 settled");
      // R7: two completions in a frame, newest data, counter +2
      drive(1, 1, 1, 1, 0, 0, 24'h0, 1, steps(8'h41), "R7 first");
      drive(1, 1, 1, 1, 0, 1, 24'hDEF002, 1, steps(8'h42), "R7 second");
      drive(1, 0, 1, 1, 0, 0, 24'h0, 0, '0, "R7 commit newest");
      // R7 / R3: four completions in a frame, counter +0 modulo 4
      for (int i = 0; i < 4; i++) drive(1, 1, 1, 1, 0, 0, 24'h0, 1, steps(8'h50 + 8'(i)), "R7 four");
      drive(1, 0, 1, 1, 0, 0, 24'h0, 0, '0, "R7 four commit");
      // R8: completion lands in the commit cycle
      drive(1, 1, 1, 1, 0, 1, 24'hDEF010, 1, steps(8'h61), "R8 hold");
      drive(1, 0, 1, 1, 0, 1, 24'hDEF011, 1, steps(8'h62), "R8 commit plus new");
      drive(1, 0, 1, 1, 0, 0, 24'h0, 0, '0, "R8 second commit");
      // R8: the extra completion waits if the frame reopens
      drive(1, 1, 1, 1, 0, 1, 24'hDEF020, 0, '0, "R8 hold p1");
      drive(1, 0, 1, 1, 0, 1, 24'hDEF021, 0, '0, "R8 commit p1");
      drive(1, 1, 1, 1, 0, 0, 24'h0, 0, '0, "R8 reopened");
      drive(1, 0, 1, 1, 0, 0, 24'h0, 0, '0, "R8 late commit");
      // R4: disabling path two drops the held update and ignores strobes
      drive(1, 1, 1, 1, 0, 0, 24'h0, 1, steps(8'h71), "R4 held before clear");
      drive(1, 1, 1, 0, 0, 0, 24'h0, 1, steps(8'h72), "R4 disable");
      drive(1, 0, 1, 0, 0, 0, 24'h0, 1, steps(8'h73), "R4 disabled ignore");
      drive(1, 0, 1, 1, 0, 0, 24'h0, 0, '0, "R4 no stale commit");
      // R4: low power clears both paths, data kept
      drive(1, 0, 1, 1, 0, 1, 24'hFED001, 1, steps(8'h81), "R2 before low power");
      drive(1, 0, 1, 1, 1, 1, 24'hFED002, 1, steps(8'h82), "R4 low power");
      drive(1, 0, 1, 1, 0, 1, 24'hFED003, 1, steps(8'h83), "R2 restart");
      drive(1, 0, 1, 1, 0, 0, 24'h0, 0, '0, "R2 end");
      repeat (3) @(posedge clk);
      #1;
      done_all = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule